// File: doc/BRIEF.md
# Latched SDRAM and Burst-Flash Address Router

This block holds a 32-bit processor address that is captured when an address-latch-enable strobe is high. From that held value it builds two separate memory address buses. The processor numbers its address bits from the most significant end, so bit 0 is the MSB. In this document, "processor bit n" means the port bit `addr_in[31-n]`.

The first bus drives a multiplexed SDRAM with 12 row and 10 column address bits. A row/column select input chooses which processor bits reach the shared pins. The two top row bits bypass that choice. Pin A10 always carries the processor's dedicated precharge output, and the two bank-select lines pass straight through. The second bus drives a burst-capable flash: its upper fifteen bits are a contiguous slice of the held address, and its lower four bits come from the processor's burst-address lines.

A parameter picks how the address is held. In edge-capture mode, the value is taken at a clock edge while the strobe is high. In transparent mode, the input shows through while the strobe is high and the last captured value is held once it drops.

Top module: `latched_addr_router`

## Requirements
- R1: In edge-capture mode (`LATCH_EDGE=1`), a clock edge with `ale` high stores `addr_in`. The outputs change only after that edge. While `ale` is low, changes on `addr_in` have no effect on any address-derived output bit, across any number of edges.
- R2: A clock edge with `rst` high clears the held address to zero. All address-derived output bits then read 0.
- R3: With `row_sel`=1 (row), `sd_addr[k]` for k=0..9 equals processor bit 17-k of the held address, i.e. `addr[14+k]`.
- R4: With `row_sel`=0 (column), `sd_addr[k]` for k=0..9 equals processor bit 29-k of the held address, i.e. `addr[2+k]`.
- R5: `sd_addr[11]` and `sd_addr[12]` equal processor bits 6 and 5 of the held address (`addr[25]`, `addr[26]`) for either value of `row_sel`.
- R6: `sd_addr[10]` equals the `precharge` input for either value of `row_sel`, independent of the held address.
- R7: `sd_bank[1:0]` equals `bank_in[1:0]` for all four codes 00, 01, 10, 11.
- R8: `fl_addr[4+m]` for m=0..14 equals processor bit 30-m of the held address. So `fl_addr[18:4]` equals `addr[15:1]`, with A4 at processor bit 30 and A18 at processor bit 16.
- R9: `fl_addr[3:0]` equals `burst_in[3:0]` bit for bit, independent of the held address.
- R10: In transparent mode (`LATCH_EDGE=0`), while `ale` is high, the outputs follow `addr_in` in the same cycle. While `ale` is low, they show the value stored at the last clock edge at which `ale` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the held address |
| ale | input | 1 | Address latch enable |
| addr_in | input | 32 | Processor address; processor bit n is `addr_in[31-n]` |
| row_sel | input | 1 | 1 selects row mapping, 0 selects column mapping |
| precharge | input | 1 | Processor precharge output, routed to SDRAM A10 |
| bank_in | input | 2 | Processor bank-select lines |
| burst_in | input | 4 | Processor burst-address lines |
| sd_addr | output | 13 | SDRAM address pins A0..A12 |
| sd_bank | output | 2 | SDRAM bank selects |
| fl_addr | output | 19 | Flash address pins A0..A18 |

## Verification
The mapping is tried with addresses of all zeros and all ones, single walking ones at both ends and in the middle of the word, and alternating and irregular patterns. Each address is tried under both select values.

A single set bit pins down one source position per output. Complementary patterns expose swapped or shifted bits. Presenting the complement of the held address while the strobe is low separates the held value from the live input.

The precharge, bank and burst inputs are varied independently of the address. This shows that they are routed apart from the held value. A second instance in transparent mode is compared against the edge-capture one around the strobe's rise and fall.

// File: rtl/lar_pkg.sv
package lar_pkg;
    localparam int unsigned PADDR_W    = 32;
    localparam int unsigned SD_A_W     = 13;
    localparam int unsigned SD_COL_W   = 10;
    localparam int unsigned SD_PRE_IDX = 10;
    localparam int unsigned SD_ROW_LSB = 17;  // processor bit feeding row A0
    localparam int unsigned SD_COL_LSB = 29;  // processor bit feeding column A0
    localparam int unsigned BANK_W     = 2;
    localparam int unsigned FL_A_W     = 19;
    localparam int unsigned FL_BURST_W = 4;
    localparam int unsigned FL_LSB     = 30;  // processor bit feeding flash A4

    typedef enum logic {RC_COL = 1'b0, RC_ROW = 1'b1} rc_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SD_A_W-1:0] addr;
    } sd_bus_t;

    // processor numbering: bit 0 is the MSB of the vector
    function automatic logic pbit(input logic [PADDR_W-1:0] a, input int unsigned n);
        return a[PADDR_W-1-n];
    endfunction
endpackage

// File: rtl/lar_latch.sv
module lar_latch #(
    parameter int unsigned W    = 32,
    parameter bit          EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ale,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)      held <= '0;
        else if (ale) held <= d;
    end

    generate
        if (EDGE) begin : g_edge
            assign q = held;
        end else begin : g_transp
            assign q = ale ? d : held;
        end
    endgenerate

    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        ale |=> held == $past(d));
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(held));
    p_clear_r2: assert property (@(posedge clk)
        rst |=> held == '0);
endmodule

// File: rtl/lar_sdram_map.sv
module lar_sdram_map
    import lar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PADDR_W-1:0]  lat,
    input  rc_sel_e             rc,
    input  logic                precharge,
    input  logic [BANK_W-1:0]   bank_in,
    output sd_bus_t             sd
);
    logic unused_lat;
    assign unused_lat = ^lat;

    genvar k;
    generate
        for (k = 0; k < SD_A_W; k++) begin : g_pin
            if (k == SD_PRE_IDX) begin : g_pre
                assign sd.addr[k] = precharge;
            end else if (k < SD_COL_W) begin : g_mux
                assign sd.addr[k] = (rc == RC_ROW) ? pbit(lat, SD_ROW_LSB - k)
                                                   : pbit(lat, SD_COL_LSB - k);
            end else begin : g_bypass
                assign sd.addr[k] = pbit(lat, SD_ROW_LSB - k);
            end
        end
    endgenerate

    assign sd.bank = bank_in;

    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        $stable(lat) |-> $stable(sd.addr[12:11]));
    p_pre_r6: assert property (@(posedge clk) disable iff (rst)
        $stable(precharge) |-> $stable(sd.addr[SD_PRE_IDX]));
    p_mux_r4: assert property (@(posedge clk) disable iff (rst)
        ($stable(lat) && $stable(rc)) |-> $stable(sd.addr[SD_COL_W-1:0]));
    p_bank_r7: assert property (@(posedge clk) disable iff (rst)
        $stable(bank_in) |-> $stable(sd.bank));
endmodule

// File: rtl/lar_flash_map.sv
module lar_flash_map
    import lar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PADDR_W-1:0]    lat,
    input  logic [FL_BURST_W-1:0] burst_in,
    output logic [FL_A_W-1:0]     fl_addr
);
    logic unused_lat;
    assign unused_lat = ^lat;

    genvar j;
    generate
        for (j = 0; j < FL_A_W; j++) begin : g_pin
            if (j < FL_BURST_W) begin : g_burst
                assign fl_addr[j] = burst_in[j];
            end else begin : g_slice
                assign fl_addr[j] = pbit(lat, FL_LSB - (j - FL_BURST_W));
            end
        end
    endgenerate

    p_burst_r9: assert property (@(posedge clk) disable iff (rst)
        $stable(burst_in) |-> $stable(fl_addr[FL_BURST_W-1:0]));
    p_slice_r8: assert property (@(posedge clk) disable iff (rst)
        $stable(lat) |-> $stable(fl_addr[FL_A_W-1:FL_BURST_W]));
endmodule

// File: rtl/latched_addr_router.sv
module latched_addr_router
    import lar_pkg::*;
#(
    parameter bit LATCH_EDGE = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ale,
    input  logic [PADDR_W-1:0]        addr_in,
    input  logic                      row_sel,
    input  logic                      precharge,
    input  logic [BANK_W-1:0]         bank_in,
    input  logic [FL_BURST_W-1:0]     burst_in,
    output logic [SD_A_W-1:0]         sd_addr,
    output logic [BANK_W-1:0]         sd_bank,
    output logic [FL_A_W-1:0]         fl_addr
);
    logic [PADDR_W-1:0] lat;
    sd_bus_t            sd;
    rc_sel_e            rc;

    assign rc = rc_sel_e'(row_sel);

    lar_latch #(.W(PADDR_W), .EDGE(LATCH_EDGE)) u_latch (
        .clk (clk),
        .rst (rst),
        .ale (ale),
        .d   (addr_in),
        .q   (lat)
    );

    lar_sdram_map u_sdram (
        .clk       (clk),
        .rst       (rst),
        .lat       (lat),
        .rc        (rc),
        .precharge (precharge),
        .bank_in   (bank_in),
        .sd        (sd)
    );

    lar_flash_map u_flash (
        .clk      (clk),
        .rst      (rst),
        .lat      (lat),
        .burst_in (burst_in),
        .fl_addr  (fl_addr)
    );

    assign sd_addr = sd.addr;
    assign sd_bank = sd.bank;
endmodule

// File: tb/latched_addr_router_bench.sv
module latched_addr_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0;
    logic [31:0] addr_in = 32'hDEAD_BEEF;
    logic        row_sel = 1'b1;
    logic        precharge = 1'b0;
    logic [1:0]  bank_in = 2'b00;
    logic [3:0]  burst_in = 4'h0;
    logic [12:0] sd_addr, sd_addr_t;
    logic [1:0]  sd_bank, sd_bank_t;
    logic [18:0] fl_addr, fl_addr_t;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    latched_addr_router #(.LATCH_EDGE(1'b1)) u_latched_addr_router (
        .clk(clk), .rst(rst), .ale(ale), .addr_in(addr_in), .row_sel(row_sel),
        .precharge(precharge), .bank_in(bank_in), .burst_in(burst_in),
        .sd_addr(sd_addr), .sd_bank(sd_bank), .fl_addr(fl_addr));

    latched_addr_router #(.LATCH_EDGE(1'b0)) u_latched_addr_router_tr (
        .clk(clk), .rst(rst), .ale(ale), .addr_in(addr_in), .row_sel(row_sel),
        .precharge(precharge), .bank_in(bank_in), .burst_in(burst_in),
        .sd_addr(sd_addr_t), .sd_bank(sd_bank_t), .fl_addr(fl_addr_t));

    localparam int NV = 10;
    localparam logic [31:0] VECS [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001,
        32'h0002_0000, 32'h0400_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
        32'h1234_5678, 32'hC3F0_0F3C
    };

    // expected SDRAM pins from R3..R6
    function automatic logic [12:0] ref_sd(input logic [31:0] a, input logic rs, input logic pre);
        logic [12:0] r;
        for (int k = 0; k < 13; k++) begin
            if (k == 10)     r[k] = pre;
            else if (k > 10) r[k] = a[14 + k];
            else             r[k] = rs ? a[14 + k] : a[2 + k];
        end
        return r;
    endfunction

    // expected flash pins from R8, R9
    function automatic logic [18:0] ref_fl(input logic [31:0] a, input logic [3:0] b);
        return {a[15:1], b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        // reset state, R2
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 sd", {19'd0, sd_addr}, 32'd0);
        chk("R2 fl", {13'd0, fl_addr}, 32'd0);
        chk("R2 tr fl", {13'd0, fl_addr_t}, 32'd0);
        rst = 1'b0;
        prev = 32'd0;

        for (int i = 0; i < NV; i++) begin
            for (int rs = 0; rs < 2; rs++) begin
                logic [31:0] v;
                logic        pre;
                logic [1:0]  bk;
                logic [3:0]  bu;
                v   = VECS[i];
                pre = v[0] ^ rs[0];
                bk  = 2'(i) ^ {1'b0, rs[0]};
                bu  = 4'(i * 3 + rs);
                @(negedge clk);
                addr_in = v; ale = 1'b1;
                #1;
                chk("R1 before edge", {17'd0, fl_addr[18:4]}, {17'd0, prev[15:1]});
                chk("R10 follow", {17'd0, fl_addr_t[18:4]}, {17'd0, v[15:1]});
                @(negedge clk);
                ale = 1'b0; addr_in = ~v; row_sel = rs[0];
                precharge = pre; bank_in = bk; burst_in = bu;
                #1;
                if (rs == 1) chk("R3 row", {22'd0, sd_addr[9:0]}, {22'd0, ref_sd(v, 1'b1, pre) & 13'h3FF});
                else         chk("R4 col", {22'd0, sd_addr[9:0]}, {22'd0, ref_sd(v, 1'b0, pre) & 13'h3FF});
                chk("R5 bypass", {30'd0, sd_addr[12:11]}, {30'd0, v[26], v[25]});
                chk("R6 a10", {31'd0, sd_addr[10]}, {31'd0, pre});
                chk("R7 bank", {30'd0, sd_bank}, {30'd0, bk});
                chk("R8 slice", {17'd0, fl_addr[18:4]}, {17'd0, v[15:1]});
                chk("R9 burst", {28'd0, fl_addr[3:0]}, {28'd0, bu});
                chk("R10 held", {19'd0, sd_addr_t}, {19'd0, ref_sd(v, rs[0], pre)});
                @(negedge clk);
                addr_in = 32'h1357_9BDF ^ v;
                #1;
                chk("R1 hold", {19'd0, sd_addr}, {19'd0, ref_sd(v, rs[0], pre)});
                chk("R1 hold fl", {13'd0, fl_addr}, {13'd0, ref_fl(v, bu)});
                prev = v;
            end
        end

        // all four bank codes, R7
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            bank_in = 2'(b);
            #1;
            chk("R7 code", {30'd0, sd_bank}, 32'(b));
        end

        // mid-run reset, R2
        @(negedge clk);
        addr_in = 32'hFFFF_FFFF; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; rst = 1'b1; precharge = 1'b0; row_sel = 1'b1; burst_in = 4'h0;
        @(negedge clk);
        #1;
        chk("R2 mid sd", {19'd0, sd_addr}, 32'd0);
        chk("R2 mid fl", {13'd0, fl_addr}, 32'd0);
        chk("R2 mid tr", {19'd0, sd_addr_t}, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule